// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code to Hex ASCII Display

This block listens to a keyboard on two input-only serial lines, a keyboard clock and a keyboard data line. It never drives either line. Each keystroke sends a make sequence when the key goes down and a break sequence when the key comes up. The block takes the last byte of every such sequence, ignores the prefix bytes in front of it, and looks that byte up in a scan-code to ASCII table. Letters come out in upper case. Digits, space and punctuation give their ASCII codes. Every other key gives 00.

The resulting byte is shown as two hexadecimal digits on a pair of active-low seven-segment outputs. The high nibble goes to the left digit and the low nibble to the right digit. A one-cycle strobe marks each display reload. The displayed byte is also available as a parallel output, aligned with the segments. Both decimal points are held dark.

The block runs on one synchronous system clock with an active-high synchronous reset. The keyboard lines are brought into that clock domain through flip-flop synchronisers, and the block detects the falling edges of the keyboard clock itself.

Top module: `ps2_ascii_display`

## Requirements
- R1: After reset, `ascii_o` is 0x00, both digits show the pattern for 0 (active-low value 7'h40), and `shown_o` is low.
- R2: A frame is a start bit of 0, eight data bits with the least significant bit first, an odd-parity bit and a stop bit of 1. Each bit is taken on a falling edge of the keyboard clock. A valid frame that carries a non-prefix byte reloads the display exactly once.
- R3: The scan codes for letters give upper-case ASCII. For example, 0x1C gives 0x41, 0x32 gives 0x42 and 0x1A gives 0x5A. No lower-case code is ever shown.
- R4: The scan codes for digits, space and punctuation give their ASCII codes. For example, 0x45 gives 0x30, 0x16 gives 0x31, 0x46 gives 0x39, 0x29 gives 0x20, 0x4E gives 0x2D and 0x4A gives 0x2F.
- R5: Every scan code that is not a character key gives 0x00. Examples are escape 0x76, F1 0x05, enter 0x5A and shift 0x12. Every shown value is either 0x00 or in the range 0x20 to 0x7E.
- R6: The prefix bytes 0xF0 (release) and 0xE0 (extended) leave the display and `shown_o` untouched. The byte that follows a prefix is decoded like any other final byte.
- R7: A frame whose start bit is 1, whose parity is even, or whose stop bit is 0 is discarded and leaves the display untouched.
- R8: If no keyboard clock falling edge arrives for `TIMEOUT_CYC` system cycles in the middle of a frame, the receiver drops the partial frame. The next complete frame is then decoded correctly.
- R9: Segment bit 0 is segment a and bit 6 is segment g, all active low. The left digit shows `ascii_o[7:4]` and the right digit shows `ascii_o[3:0]`, using the usual hex glyphs 0-9 and A, b, C, d, E, F.
- R10: Both decimal-point outputs stay high (dark) at all times.
- R11: `shown_o` is high for exactly one cycle per reload. It rises in the cycle in which the new segments and `ascii_o` first appear. Between strobes, the segments and `ascii_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous, idle high) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous, idle high) |
| ascii_o | output | 8 | Byte currently shown on the digits |
| shown_o | output | 1 | One-cycle strobe on each display reload |
| seg_hi_n_o | output | 7 | Left digit segments g..a, active low |
| seg_lo_n_o | output | 7 | Right digit segments g..a, active low |
| dp_hi_n_o | output | 1 | Left decimal point, active low |
| dp_lo_n_o | output | 1 | Right decimal point, active low |

## Verification
The assertions assume three things about the inputs:
- The keyboard clock falls far less often than once per system cycle, so two display reloads can never come in consecutive cycles.
- Reset is held from time zero until the first checked edge.
- The keyboard lines idle high.

The stimulus keeps to these assumptions. It toggles the keyboard clock with a half period of many system cycles, and it changes data only while the keyboard clock is high. It also leaves idle gaps between frames that stay below the timeout, except in the one deliberate timeout case.

// File: rtl/ps2a_pkg.sv
package ps2a_pkg;

  localparam logic [7:0] SC_RELEASE = 8'hF0;
  localparam logic [7:0] SC_EXTEND  = 8'hE0;

  // Last byte of a make/break sequence -> ASCII (00 for non-characters)
  function automatic logic [7:0] scan_to_ascii(input logic [7:0] sc);
    logic [7:0] a;
    case (sc)
      8'h1C: a = 8'h41; 8'h32: a = 8'h42; 8'h21: a = 8'h43; 8'h23: a = 8'h44;
      8'h24: a = 8'h45; 8'h2B: a = 8'h46; 8'h34: a = 8'h47; 8'h33: a = 8'h48;
      8'h43: a = 8'h49; 8'h3B: a = 8'h4A; 8'h42: a = 8'h4B; 8'h4B: a = 8'h4C;
      8'h3A: a = 8'h4D; 8'h31: a = 8'h4E; 8'h44: a = 8'h4F; 8'h4D: a = 8'h50;
      8'h15: a = 8'h51; 8'h2D: a = 8'h52; 8'h1B: a = 8'h53; 8'h2C: a = 8'h54;
      8'h3C: a = 8'h55; 8'h2A: a = 8'h56; 8'h1D: a = 8'h57; 8'h22: a = 8'h58;
      8'h35: a = 8'h59; 8'h1A: a = 8'h5A;
      8'h45: a = 8'h30; 8'h16: a = 8'h31; 8'h1E: a = 8'h32; 8'h26: a = 8'h33;
      8'h25: a = 8'h34; 8'h2E: a = 8'h35; 8'h36: a = 8'h36; 8'h3D: a = 8'h37;
      8'h3E: a = 8'h38; 8'h46: a = 8'h39;
      8'h29: a = 8'h20; 8'h0E: a = 8'h60; 8'h4E: a = 8'h2D; 8'h55: a = 8'h3D;
      8'h5D: a = 8'h5C; 8'h54: a = 8'h5B; 8'h5B: a = 8'h5D; 8'h4C: a = 8'h3B;
      8'h52: a = 8'h27; 8'h41: a = 8'h2C; 8'h49: a = 8'h2E; 8'h4A: a = 8'h2F;
      default: a = 8'h00;
    endcase
    return a;
  endfunction

  // Hex nibble -> segments {g,f,e,d,c,b,a}, active high
  function automatic logic [6:0] nibble_glyph(input logic [3:0] n);
    logic [6:0] s;
    case (n)
      4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
      4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
      4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
      4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ps2a_sync.sv
module ps2a_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] fall_o
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '1;
          prev  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], async_i[gi]};
          prev  <= chain[STAGES-1];
        end
      end
      assign sync_o[gi] = chain[STAGES-1];
      assign fall_o[gi] = prev & ~chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ps2a_rx.sv
module ps2a_rx #(
  parameter int TIMEOUT_CYC = 125000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  localparam int TW       = $clog2(TIMEOUT_CYC + 1);
  localparam int PAYLOAD  = 9;          // 8 data + parity
  localparam int CW       = $clog2(PAYLOAD + 2);
  localparam logic [CW-1:0] STOP_IDX = CW'(PAYLOAD);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYC - 1);

  typedef enum logic {RX_IDLE, RX_BITS} rx_state_e;

  rx_state_e          state;
  logic [CW-1:0]      bit_idx;
  logic [PAYLOAD-1:0] shreg;
  logic [TW-1:0]      tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      bit_idx    <= '0;
      shreg      <= '0;
      tmr        <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      case (state)
        RX_IDLE: begin
          tmr <= '0;
          if (fall_i && !dat_i) begin
            state   <= RX_BITS;
            bit_idx <= '0;
          end
        end
        default: begin
          if (fall_i) begin
            tmr <= '0;
            if (bit_idx == STOP_IDX) begin
              state <= RX_IDLE;
              if (dat_i && (^shreg)) begin
                byte_o     <= shreg[7:0];
                byte_vld_o <= 1'b1;
              end
            end else begin
              shreg   <= {dat_i, shreg[PAYLOAD-1:1]};
              bit_idx <= bit_idx + 1'b1;
            end
          end else if (tmr == TMR_LAST) begin
            state <= RX_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ps2a_keyseq.sv
module ps2a_keyseq
  import ps2a_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_i,
  input  logic       vld_i,
  output logic [7:0] ascii_o,
  output logic       upd_o
);
  logic is_prefix;
  assign is_prefix = (byte_i == SC_RELEASE) || (byte_i == SC_EXTEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      ascii_o <= 8'h00;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (vld_i && !is_prefix) begin
        ascii_o <= scan_to_ascii(byte_i);
        upd_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2a_hexdisp.sv
module ps2a_hexdisp
  import ps2a_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4*NDIG-1:0] val_i,
  input  logic              stb_i,
  output logic [4*NDIG-1:0] val_o,
  output logic [7*NDIG-1:0] seg_n_o,
  output logic [NDIG-1:0]   dp_n_o,
  output logic              stb_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= '0;
      stb_o <= 1'b0;
    end else begin
      val_o <= val_i;
      stb_o <= stb_i;
    end
  end

  genvar gd;
  generate
    for (gd = 0; gd < NDIG; gd++) begin : g_dig
      always_ff @(posedge clk) begin
        if (rst) begin
          seg_n_o[7*gd +: 7] <= ~nibble_glyph(4'h0);
          dp_n_o[gd]         <= 1'b1;
        end else begin
          seg_n_o[7*gd +: 7] <= ~nibble_glyph(val_i[4*gd +: 4]);
          dp_n_o[gd]         <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ps2_ascii_display.sv
module ps2_ascii_display #(
  parameter int TIMEOUT_CYC = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  output logic [7:0] ascii_o,
  output logic       shown_o,
  output logic [6:0] seg_hi_n_o,
  output logic [6:0] seg_lo_n_o,
  output logic       dp_hi_n_o,
  output logic       dp_lo_n_o
);
  localparam int NDIG = 2;

  logic [1:0]        ln_sync, ln_fall;
  logic [7:0]        rx_byte, key_ascii;
  logic              rx_vld, key_upd;
  logic [7*NDIG-1:0] seg_n;
  logic [NDIG-1:0]   dp_n;

  ps2a_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({kb_dat_i, kb_clk_i}),
    .sync_o(ln_sync), .fall_o(ln_fall)
  );

  ps2a_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk(clk), .rst(rst),
    .fall_i(ln_fall[0]), .dat_i(ln_sync[1]),
    .byte_o(rx_byte), .byte_vld_o(rx_vld)
  );

  ps2a_keyseq u_seq (
    .clk(clk), .rst(rst),
    .byte_i(rx_byte), .vld_i(rx_vld),
    .ascii_o(key_ascii), .upd_o(key_upd)
  );

  ps2a_hexdisp #(.NDIG(NDIG)) u_hex (
    .clk(clk), .rst(rst),
    .val_i(key_ascii), .stb_i(key_upd),
    .val_o(ascii_o), .seg_n_o(seg_n), .dp_n_o(dp_n), .stb_o(shown_o)
  );

  assign seg_lo_n_o = seg_n[6:0];
  assign seg_hi_n_o = seg_n[13:7];
  assign dp_lo_n_o  = dp_n[0];
  assign dp_hi_n_o  = dp_n[1];
endmodule

// File: rtl/ps2a_chk.sv
module ps2a_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ascii_o,
  input logic       shown_o,
  input logic [6:0] seg_hi_n_o,
  input logic [6:0] seg_lo_n_o,
  input logic       dp_hi_n_o,
  input logic       dp_lo_n_o
);
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    shown_o |=> !shown_o);

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (rst)
    !shown_o |-> ($stable(seg_hi_n_o) && $stable(seg_lo_n_o) && $stable(ascii_o)));

  assert_dp_dark_R10: assert property (@(posedge clk) disable iff (rst)
    dp_hi_n_o && dp_lo_n_o);

  assert_charset_R5: assert property (@(posedge clk) disable iff (rst)
    shown_o |-> (ascii_o == 8'h00 || (ascii_o >= 8'h20 && ascii_o <= 8'h7E)));

  assert_upper_only_R3: assert property (@(posedge clk) disable iff (rst)
    shown_o |-> !(ascii_o >= 8'h61 && ascii_o <= 8'h7A));
endmodule

bind ps2_ascii_display ps2a_chk u_chk (
  .clk(clk), .rst(rst), .ascii_o(ascii_o), .shown_o(shown_o),
  .seg_hi_n_o(seg_hi_n_o), .seg_lo_n_o(seg_lo_n_o),
  .dp_hi_n_o(dp_hi_n_o), .dp_lo_n_o(dp_lo_n_o)
);

// File: tb/ps2_ascii_display_tb.sv
module ps2_ascii_display_tb;
  localparam int TMO  = 200;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kb_clk = 1'b1;
  logic kb_dat = 1'b1;
  logic [7:0] ascii;
  logic shown;
  logic [6:0] seg_hi, seg_lo;
  logic dp_hi, dp_lo;

  int n_run = 0, n_fail = 0, n_shown = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  ps2_ascii_display #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .ascii_o(ascii), .shown_o(shown), .seg_hi_n_o(seg_hi), .seg_lo_n_o(seg_lo),
    .dp_hi_n_o(dp_hi), .dp_lo_n_o(dp_lo)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] n);
    logic [6:0] on;
    case (n)
      0: on = 7'b0111111; 1: on = 7'b0000110; 2: on = 7'b1011011; 3: on = 7'b1001111;
      4: on = 7'b1100110; 5: on = 7'b1101101; 6: on = 7'b1111101; 7: on = 7'b0000111;
      8: on = 7'b1111111; 9: on = 7'b1101111; 10: on = 7'b1110111; 11: on = 7'b1111100;
      12: on = 7'b0111001; 13: on = 7'b1011110; 14: on = 7'b1111001; default: on = 7'b1110001;
    endcase
    return ~on;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic put_bit(input logic b);
    kb_dat = b;
    cyc(HALF);
    kb_clk = 1'b0;
    cyc(HALF);
    kb_clk = 1'b1;
  endtask

  task automatic frame(input logic [7:0] d, input logic st, input bit bad_par, input logic sp);
    put_bit(st);
    for (int i = 0; i < 8; i++) put_bit(d[i]);
    put_bit(~(^d) ^ bad_par);
    put_bit(sp);
    kb_dat = 1'b1;
    cyc(3 * HALF);
  endtask

  task automatic key(input logic [7:0] sc, input logic [7:0] exp);
    exp_q.push_back(exp);
    frame(sc, 1'b0, 1'b0, 1'b1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(dp_hi && dp_lo, "R10 dp dark", {dp_hi, dp_lo}, 3);
      if (shown) begin
        n_shown++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected reload", ascii, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(ascii == e, "R2 ascii value", ascii, e);
          check(seg_hi == exp_seg(e[7:4]), "R9 left digit", seg_hi, exp_seg(e[7:4]));
          check(seg_lo == exp_seg(e[3:0]), "R9 right digit", seg_lo, exp_seg(e[3:0]));
        end
      end
    end
  end

  initial begin
    cyc(150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    cyc(5);
    @(negedge clk);
    check(ascii == 8'h00, "R1 reset ascii", ascii, 0);
    check(seg_hi == 7'h40 && seg_lo == 7'h40, "R1 reset segs", {seg_hi, seg_lo}, 14'h2040);
    check(!shown, "R1 reset strobe", shown, 0);
    rst = 1'b0;
    cyc(20);

    // R3 letters
    key(8'h1C, 8'h41); key(8'h32, 8'h42); key(8'h1A, 8'h5A);
    // R4 digits, space, punctuation
    key(8'h45, 8'h30); key(8'h16, 8'h31); key(8'h46, 8'h39);
    key(8'h29, 8'h20); key(8'h4E, 8'h2D); key(8'h4A, 8'h2F);
    // R5 non-character keys
    key(8'h76, 8'h00); key(8'h05, 8'h00); key(8'h5A, 8'h00); key(8'h12, 8'h00);

    // R6 release prefix alone leaves display unchanged
    key(8'h2C, 8'h54);
    c0 = n_shown;
    frame(8'hF0, 1'b0, 1'b0, 1'b1);
    check(n_shown == c0, "R6 F0 no reload", n_shown, c0);
    check(ascii == 8'h54, "R6 F0 held value", ascii, 8'h54);
    key(8'h2C, 8'h54);
    check(n_shown == c0 + 1, "R6 break final byte", n_shown, c0 + 1);
    c0 = n_shown;
    frame(8'hE0, 1'b0, 1'b0, 1'b1);
    check(n_shown == c0 && ascii == 8'h54, "R6 E0 no reload", ascii, 8'h54);
    key(8'h4A, 8'h2F);

    // R7 bad parity, bad stop, bad start
    c0 = n_shown;
    frame(8'h15, 1'b0, 1'b1, 1'b1);
    check(n_shown == c0 && ascii == 8'h2F, "R7 bad parity", ascii, 8'h2F);
    frame(8'h15, 1'b0, 1'b0, 1'b0);
    cyc(2 * TMO);
    check(n_shown == c0 && ascii == 8'h2F, "R7 bad stop", ascii, 8'h2F);
    frame(8'hFF, 1'b1, 1'b0, 1'b1);
    cyc(2 * TMO);
    check(n_shown == c0 && ascii == 8'h2F, "R7 bad start", ascii, 8'h2F);

    // R8 partial frame then timeout
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    kb_dat = 1'b1;
    cyc(2 * TMO);
    check(n_shown == c0, "R8 partial frame dropped", n_shown, c0);
    key(8'h15, 8'h51);
    check(ascii == 8'h51, "R8 resync value", ascii, 8'h51);

    // R11 same key twice gives two reloads
    c0 = n_shown;
    key(8'h15, 8'h51);
    key(8'h15, 8'h51);
    check(n_shown == c0 + 2, "R11 repeat reloads", n_shown, c0 + 2);

    cyc(50);
    check(exp_q.size() == 0, "R2 all frames shown", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule